// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block puts two independent memory ports, left and right, in front of one shared two-port storage array. Each port has its own enable, address, write enable, write data and read data. In every cycle the block compares the two requests. When both ports are enabled and point at the same word, one port is allowed through and the other receives a busy flag. A write from the flagged port is dropped inside the block, so the requester can stall and retry.

The winner is the port whose request was already in place. A request counts as newly arrived in a cycle when its enable has just risen or its address has just changed while enabled. The port that arrived later is flagged. When both arrive in the same cycle, the fixed rule flags the right port. A mode input turns the arbiter off. In that mode the busy outputs stay low and each port's external busy input acts only as a write inhibit for that port. Reads are synchronous with one cycle of latency, and they return the word as it was before any write at the same edge.

Top module: `dualport_collision_arb`

## Requirements
- R1: In master mode (`slave_mode`=0) a busy output is high only while both enables are high and the two addresses are equal. A port that is disabled, or an address mismatch, keeps both busy outputs low.
- R2: `l_busy_out` and `r_busy_out` are never high in the same cycle.
- R3: A request is new in a cycle if its enable was low in the previous cycle or its address differs from the previous cycle. If one colliding request is new and the other is not, the new one receives busy.
- R4: If both colliding requests are new in the same cycle, the right port receives busy and the left port proceeds.
- R5: While a collision persists with neither request new, the same port stays busy. Busy drops combinationally in the first cycle in which the addresses differ or either enable is low.
- R6: In master mode a write from a port whose busy output is high does not modify the array. The winning port's write in that cycle does modify it.
- R7: In slave mode both busy outputs stay low. A high `l_busy_in` or `r_busy_in` blocks that port's write, and the port's read still completes.
- R8: In master mode `l_busy_in` and `r_busy_in` have no effect. Write blocking follows only the internally computed busy.
- R9: A port whose enable is low performs no write and its read data register holds its previous value.
- R10: Read data appears on `l_rdata`/`r_rdata` one clock edge after an enabled request. It carries the array contents from before any write at that edge, and the busy side's read data is returned as well.
- R11: When both ports write the same word at the same edge (possible only in slave mode), the left port's data is stored.
- R12: Synchronous active-low reset clears both read data registers to zero and clears the arrival history, so the first enabled requests after reset count as new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slave_mode | input | 1 | 1: arbiter off, busy inputs inhibit writes; 0: arbiter drives busy outputs |
| l_en | input | 1 | Left port enable; low means standby |
| l_addr | input | ADDR_W | Left port word address |
| l_we | input | 1 | Left port write request |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle after the request |
| l_busy_in | input | 1 | Left write inhibit, used in slave mode only |
| l_busy_out | output | 1 | Left port lost a collision this cycle |
| r_en | input | 1 | Right port enable; low means standby |
| r_addr | input | ADDR_W | Right port word address |
| r_we | input | 1 | Right port write request |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle after the request |
| r_busy_in | input | 1 | Right write inhibit, used in slave mode only |
| r_busy_out | output | 1 | Right port lost a collision this cycle |

## Verification
Busy outputs are combinational on the current request and on the arrival history registered at the previous edge. The bench drives inputs just after the falling edge and compares the busy outputs one time step later, in the same cycle. Read data and the effect of a write appear after the next rising edge. The bench therefore compares read data at the following falling edge against a model updated at that rising edge. Blocked and standby writes are confirmed by reading the word back on a later cycle through the normal port.

// File: rtl/dpc_pkg.sv
// Package: shared constants for the dual-port collision arbiter.
// Assumes exactly two ports, indexed left then right.
package dpc_pkg;

    localparam int NPORTS = 2;

    // Port index used for every per-port vector in the block.
    typedef enum logic {
        PORT_L = 1'b0,
        PORT_R = 1'b1
    } port_e;

endpackage

// File: rtl/dpc_arrival_track.sv
// Module: dpc_arrival_track
// Remembers one port's enable and address from the previous cycle and flags
// a request as new when the enable has just risen or the address has moved.
// Assumes a synchronous active-low reset. After reset every enabled request
// counts as new.
module dpc_arrival_track #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              fresh
);

    logic              prev_en;
    logic [ADDR_W-1:0] prev_addr;

    // Capture this cycle's request as history for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en   <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_en   <= en;
            prev_addr <= addr;
        end
    end

    // A request is new unless it is identical to last cycle's enabled one.
    always_comb begin
        fresh = en && (!prev_en || (prev_addr != addr));
    end

endmodule

// File: rtl/dpc_arbiter.sv
// Module: dpc_arbiter
// Decides which colliding port is flagged busy. The newly arrived port loses.
// On a tie the right port loses. A persisting collision keeps its loser.
// Assumes the arrival flags come from dpc_arrival_track. With slave_mode set
// the arbiter is off and both busy outputs stay low.
module dpc_arbiter
    import dpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic [NPORTS-1:0] en,
    input  logic              addr_eq,
    input  logic [NPORTS-1:0] fresh,
    output logic [NPORTS-1:0] busy
);

    logic collide;
    logic right_loses;
    logic right_lost_q;

    // Detect a same-word collision between two enabled ports.
    always_comb begin
        collide = !slave_mode && en[PORT_L] && en[PORT_R] && addr_eq;
    end

    // Pick the loser from the arrival flags, or keep the previous loser.
    always_comb begin
        unique case ({fresh[PORT_L], fresh[PORT_R]})
            2'b11:   right_loses = 1'b1;
            2'b01:   right_loses = 1'b1;
            2'b10:   right_loses = 1'b0;
            default: right_loses = right_lost_q;
        endcase
    end

    // Drive busy to the losing side only while a collision is present.
    always_comb begin
        busy[PORT_R] = collide && right_loses;
        busy[PORT_L] = collide && !right_loses;
    end

    // Remember the loser so that a persisting collision keeps it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            right_lost_q <= 1'b1;
        end else if (collide) begin
            right_lost_q <= right_loses;
        end else begin
            right_lost_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dpc_tworam.sv
// Module: dpc_tworam
// Behavioural two-port storage array with registered read data.
// Reads return the contents from before the write at the same edge.
// When both ports write the same word, port A's data is kept.
// Assumes the array itself is not reset; only the read registers are.
module dpc_tworam #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_wr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Update the array. Port A is written last so it wins a same-word clash.
    always_ff @(posedge clk) begin
        if (b_wr) begin
            mem[b_addr] <= b_wdata;
        end
        if (a_wr) begin
            mem[a_addr] <= a_wdata;
        end
    end

    // Register port A's read of the old contents while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_rdata <= '0;
        end else if (a_en) begin
            a_rdata <= mem[a_addr];
        end
    end

    // Register port B's read of the old contents while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_rdata <= '0;
        end else if (b_en) begin
            b_rdata <= mem[b_addr];
        end
    end

endmodule

// File: rtl/dualport_collision_arb.sv
// Module: dualport_collision_arb
// Top level: two memory ports share one array. Same-word collisions are
// arbitrated by arrival order, and the busy side's write is dropped.
// In slave mode the busy inputs act only as per-port write inhibits.
// Assumes a single clock and a synchronous active-low reset.
module dualport_collision_arb
    import dpc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_in,
    output logic              r_busy_out
);

    logic [NPORTS-1:0]  en_v;
    logic [NPORTS-1:0]  we_v;
    logic [NPORTS-1:0]  ext_inhibit_v;
    logic [ADDR_W-1:0]  addr_v [NPORTS];
    logic [NPORTS-1:0]  fresh_v;
    logic [NPORTS-1:0]  busy_v;
    logic [NPORTS-1:0]  inhibit_v;
    logic [NPORTS-1:0]  wr_go_v;
    logic               l_wr_go;
    logic               r_wr_go;

    // Gather the per-port request fields into indexed vectors.
    always_comb begin
        en_v[PORT_L]          = l_en;
        en_v[PORT_R]          = r_en;
        we_v[PORT_L]          = l_we;
        we_v[PORT_R]          = r_we;
        ext_inhibit_v[PORT_L] = l_busy_in;
        ext_inhibit_v[PORT_R] = r_busy_in;
        addr_v[PORT_L]        = l_addr;
        addr_v[PORT_R]        = r_addr;
    end

    // One arrival tracker and one write gate per port.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        dpc_arrival_track #(
            .ADDR_W (ADDR_W)
        ) u_arrival (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_v[p]),
            .addr  (addr_v[p]),
            .fresh (fresh_v[p])
        );

        // Choose the inhibit source: the external pin in slave mode, else the internal busy.
        always_comb begin
            inhibit_v[p] = slave_mode ? ext_inhibit_v[p] : busy_v[p];
            wr_go_v[p]   = en_v[p] && we_v[p] && !inhibit_v[p];
        end
    end

    dpc_arbiter u_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .en         (en_v),
        .addr_eq    (l_addr == r_addr),
        .fresh      (fresh_v),
        .busy       (busy_v)
    );

    // Bring the per-port results out to named signals.
    always_comb begin
        l_busy_out = busy_v[PORT_L];
        r_busy_out = busy_v[PORT_R];
        l_wr_go    = wr_go_v[PORT_L];
        r_wr_go    = wr_go_v[PORT_R];
    end

    dpc_tworam #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_en    (l_en),
        .a_addr  (l_addr),
        .a_wr    (l_wr_go),
        .a_wdata (l_wdata),
        .a_rdata (l_rdata),
        .b_en    (r_en),
        .b_addr  (r_addr),
        .b_wr    (r_wr_go),
        .b_wdata (r_wdata),
        .b_rdata (r_rdata)
    );

endmodule

// File: rtl/dpc_checker.sv
// Module: dpc_checker
// Property checks for dualport_collision_arb, attached with bind below.
// Assumes the bound instance exposes its gated write strobes.
module dpc_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slave_mode,
    input logic              l_en,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_we,
    input logic [DATA_W-1:0] l_rdata,
    input logic              l_busy_in,
    input logic              l_busy_out,
    input logic              r_en,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_we,
    input logic [DATA_W-1:0] r_rdata,
    input logic              r_busy_in,
    input logic              r_busy_out,
    input logic              l_wr_go,
    input logic              r_wr_go
);

    assert_busy_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_out || r_busy_out) |-> (l_en && r_en && (l_addr == r_addr)));

    assert_busy_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_busy_out && r_busy_out));

    assert_loser_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (l_busy_out && $past(l_en) && $past(r_en) && $stable(l_addr) && $stable(r_addr)
         && !slave_mode && !$past(slave_mode)) |-> $past(l_busy_out));

    assert_busy_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && (l_busy_out || r_busy_out)) |->
            ((l_busy_out -> !l_wr_go) && (r_busy_out -> !r_wr_go)));

    assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slave_mode |-> (!l_busy_out && !r_busy_out
                        && (l_busy_in -> !l_wr_go) && (r_busy_in -> !r_wr_go)));

    assert_master_pin_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_mode && l_en && l_we && !l_busy_out) |-> l_wr_go);

    assert_standby_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_en && !r_en) |=> ($stable(l_rdata) && $stable(r_rdata)));

    assert_standby_nowrite_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !((!l_en && l_wr_go) || (!r_en && r_wr_go) || (!r_we && r_wr_go)));

endmodule

bind dualport_collision_arb dpc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_dpc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .slave_mode (slave_mode),
    .l_en       (l_en),
    .l_addr     (l_addr),
    .l_we       (l_we),
    .l_rdata    (l_rdata),
    .l_busy_in  (l_busy_in),
    .l_busy_out (l_busy_out),
    .r_en       (r_en),
    .r_addr     (r_addr),
    .r_we       (r_we),
    .r_rdata    (r_rdata),
    .r_busy_in  (r_busy_in),
    .r_busy_out (r_busy_out),
    .l_wr_go    (l_wr_go),
    .r_wr_go    (r_wr_go)
);

// File: tb/dualport_collision_arb_tb.sv
`timescale 1ns/1ps
module dualport_collision_arb_tb;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slave_mode = 1'b0;
    logic          l_en = 1'b0, r_en = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_we = 1'b0, r_we = 1'b0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic          l_busy_in = 1'b0, r_busy_in = 1'b0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic          l_busy_out, r_busy_out;

    int n_checks = 0;
    int n_fails  = 0;

    // Reference state kept by the bench.
    bit            m_pl_en, m_pr_en;
    logic [AW-1:0] m_pl_addr, m_pr_addr;
    bit            m_rlose;
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_val [DEPTH];
    logic [DW-1:0] e_l, e_r;
    bit            e_lv, e_rv;
    bit            exp_lb, exp_rb;

    always #2.5 clk = ~clk;

    dualport_collision_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
        .l_en(l_en), .l_addr(l_addr), .l_we(l_we), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_en(r_en), .r_addr(r_addr), .r_we(r_we), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Expected busy from the arrival-order rules (R1, R3, R4, R5).
    function automatic void model_busy(output bit lb, output bit rb, output bit rl_out);
        bit collide, lf, rf, rl;
        collide = !slave_mode && l_en && r_en && (l_addr == r_addr);
        lf = l_en && (!m_pl_en || m_pl_addr != l_addr);
        rf = r_en && (!m_pr_en || m_pr_addr != r_addr);
        if (lf && rf)      rl = 1'b1;
        else if (rf)       rl = 1'b1;
        else if (lf)       rl = 1'b0;
        else               rl = m_rlose;
        rb = collide && rl;
        lb = collide && !rl;
        rl_out = collide ? rl : 1'b1;
    endfunction

    // One cycle: inputs are already set after a falling edge.
    task automatic cycle(string tag);
        bit rl_next, lok, rok;
        #1;
        model_busy(exp_lb, exp_rb, rl_next);
        check(tag, "l_busy_out", {31'd0, l_busy_out}, {31'd0, exp_lb});
        check(tag, "r_busy_out", {31'd0, r_busy_out}, {31'd0, exp_rb});
        @(posedge clk);
        lok = l_en && l_we && !(slave_mode ? l_busy_in : exp_lb);
        rok = r_en && r_we && !(slave_mode ? r_busy_in : exp_rb);
        if (l_en) begin e_l = m_mem[l_addr]; e_lv = m_val[l_addr]; end
        if (r_en) begin e_r = m_mem[r_addr]; e_rv = m_val[r_addr]; end
        if (rok) begin m_mem[r_addr] = r_wdata; m_val[r_addr] = 1'b1; end
        if (lok) begin m_mem[l_addr] = l_wdata; m_val[l_addr] = 1'b1; end
        m_rlose = rl_next;
        m_pl_en = l_en; m_pl_addr = l_addr;
        m_pr_en = r_en; m_pr_addr = r_addr;
        @(negedge clk);
        if (e_lv) check(tag, "l_rdata (R10)", {16'd0, l_rdata}, {16'd0, e_l});
        if (e_rv) check(tag, "r_rdata (R10)", {16'd0, r_rdata}, {16'd0, e_r});
    endtask

    task automatic set_l(bit en, logic [AW-1:0] a, bit we, logic [DW-1:0] d);
        l_en = en; l_addr = a; l_we = we; l_wdata = d;
    endtask

    task automatic set_r(bit en, logic [AW-1:0] a, bit we, logic [DW-1:0] d);
        r_en = en; r_addr = a; r_we = we; r_wdata = d;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed_ret;
        m_pl_en = 0; m_pr_en = 0; m_pl_addr = '0; m_pr_addr = '0; m_rlose = 1'b1;
        e_l = '0; e_r = '0; e_lv = 1'b1; e_rv = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_val[i] = 1'b0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: reset state.
        check("R12", "l_rdata after reset", {16'd0, l_rdata}, 32'd0);
        check("R12", "r_rdata after reset", {16'd0, r_rdata}, 32'd0);
        check("R12", "busy idle", {30'd0, l_busy_out, r_busy_out}, 32'd0);
        @(negedge clk);

        // Preload words 0..7 from the left, right idle (R1).
        for (int a = 0; a < 8; a++) begin
            set_l(1, a[AW-1:0], 1, 16'h1000 + 16'(a));
            cycle("R1");
        end
        // R1: different addresses, both enabled.
        set_l(1, 6'd1, 0, 0); set_r(1, 6'd2, 0, 0); cycle("R1");
        // R3: left holds word 2, right arrives at word 2 and tries to write.
        set_l(1, 6'd2, 0, 0); set_r(0, 6'd0, 0, 0); cycle("R3");
        set_r(1, 6'd2, 1, 16'hBAD1); cycle("R3");
        // R5: collision persists, loser stays right; R6: its write is dropped.
        set_r(1, 6'd2, 1, 16'hBAD2); cycle("R5");
        // R5: addresses differ, busy drops the same cycle.
        set_r(1, 6'd3, 0, 0); cycle("R5");
        // R6: read back word 2, must still be 1002.
        set_l(0, 0, 0, 0); set_r(1, 6'd2, 0, 0); cycle("R6");
        check("R6", "word 2 after blocked write", {16'd0, r_rdata}, 32'h1002);
        // R3: right holds word 4, left arrives and writes, left is busy.
        set_l(0, 0, 0, 0); set_r(1, 6'd4, 0, 0); cycle("R3");
        set_l(1, 6'd4, 1, 16'hBAD3); cycle("R3");
        set_l(0, 0, 0, 0); set_r(1, 6'd4, 0, 0); cycle("R6");
        cycle("R6");
        check("R6", "word 4 after blocked write", {16'd0, r_rdata}, 32'h1004);
        // R4: both arrive together at word 5 and both write; right is busy.
        set_l(0, 0, 0, 0); set_r(0, 0, 0, 0); cycle("R4");
        set_l(1, 6'd5, 1, 16'hAAAA); set_r(1, 6'd5, 1, 16'h5555); cycle("R4");
        set_l(1, 6'd5, 0, 0); set_r(0, 0, 0, 0); cycle("R4");
        cycle("R4");
        check("R4", "word 5 holds winner data", {16'd0, l_rdata}, 32'hAAAA);
        // R9: standby write ignored, read data held.
        set_l(0, 6'd6, 1, 16'hDEAD); set_r(0, 0, 0, 0); cycle("R9");
        check("R9", "l_rdata held in standby", {16'd0, l_rdata}, 32'hAAAA);
        set_l(1, 6'd6, 0, 0); cycle("R9");
        check("R9", "word 6 untouched", {16'd0, l_rdata}, 32'h1006);
        // R8: master mode ignores a high busy input.
        l_busy_in = 1'b1; r_busy_in = 1'b1;
        set_l(1, 6'd7, 1, 16'h7777); set_r(0, 0, 0, 0); cycle("R8");
        l_busy_in = 1'b0; r_busy_in = 1'b0;
        set_l(1, 6'd7, 0, 0); cycle("R8");
        check("R8", "word 7 written despite pin", {16'd0, l_rdata}, 32'h7777);
        // R7: slave mode, colliding ports, left inhibited by pin.
        slave_mode = 1'b1; l_busy_in = 1'b1;
        set_l(1, 6'd0, 1, 16'hBAD4); set_r(1, 6'd0, 1, 16'h0C0C); cycle("R7");
        l_busy_in = 1'b0;
        set_l(1, 6'd0, 0, 0); set_r(0, 0, 0, 0); cycle("R7");
        cycle("R7");
        check("R7", "word 0 from right only", {16'd0, l_rdata}, 32'h0C0C);
        // R11: slave mode, both write word 1, left data stored.
        set_l(1, 6'd1, 1, 16'h1111); set_r(1, 6'd1, 1, 16'h2222); cycle("R11");
        set_l(0, 0, 0, 0); set_r(1, 6'd1, 0, 0); cycle("R11");
        cycle("R11");
        check("R11", "word 1 holds left data", {16'd0, r_rdata}, 32'h1111);
        slave_mode = 1'b0;
        set_r(0, 0, 0, 0); cycle("R1");

        // Random phase over a small address window to force collisions.
        seed_ret = $urandom(32'd20240611);
        for (int i = 0; i < 600; i++) begin
            int unsigned r;
            r = $urandom;
            slave_mode = ((r & 32'h1F) == 0);
            l_busy_in  = r[5];
            r_busy_in  = r[6];
            if (r[9:7] != 0) begin
                set_l(r[10] | r[11], l_en && r[12] ? l_addr : {3'b000, r[15:13]},
                      r[16], 16'($urandom));
            end
            if (r[19:17] != 0) begin
                set_r(r[20] | r[21], r_en && r[22] ? r_addr : {3'b000, r[25:23]},
                      r[26], 16'($urandom));
            end
            cycle(i[0] ? "R2" : "R3");
        end
        finish_run();
    end

endmodule